// File: doc/BRIEF.md
# Receive FIFO DMA Request Gate

This block sits beside an Ethernet receive FIFO and decides when the bus-master DMA should begin moving a frame out of it. It watches frame boundaries, counts the bytes of the frame in progress and compares the FIFO fill level against a watermark chosen by a 2-bit code. It then drives a request level toward the DMA engine. When a frame has to be dropped before any transfer began, it gives a one-cycle discard strobe instead, so that the FIFO can throw away that frame's bytes.

The block works in two ways. In gated operation (half duplex, runt acceptance off), no request is raised until the frame has passed the minimum length of 64 bytes. After that point, the watermark or a good frame end raises the request. In bypass operation (full duplex, or runt acceptance on), the 64-byte hold does not apply. The request then rises as soon as the watermark is met or a good frame completes, whatever its length. The mode is captured at each start of frame.

The byte strobe is an observation of the receive stream and not a handshake. The block never applies back-pressure, and every input is a plain level or pulse. The block assumes that the start-of-frame and end-of-frame cycles carry no data byte.

Top module: `rx_dma_gate`

## Requirements
- R1: In gated mode, `dma_req_o` stays low for a frame until 64 bytes of that frame have been counted, whatever the FIFO level.
- R2: In gated mode, once 64 bytes are counted, the request rises when `fifo_count_i` is at or above the watermark, or at a good frame end if it has not risen already.
- R3: In gated mode, a frame that ends with `eof_good_i` low, or ends good with fewer than 64 bytes, before any request was raised, gives `discard_o` for exactly one cycle, starting the cycle after the end pulse. That frame never raises `dma_req_o`.
- R4: With `full_duplex_i` high at start of frame, the request rises when the watermark is met or at a good frame end of any length. A bad end before any request gives the discard strobe.
- R5: With `runt_accept_i` high and `full_duplex_i` low at start of frame, the behaviour is identical to R4.
- R6: `wm_sel_i` selects the watermark: code 0 = 16 bytes, 1 = 64, 2 = 112, 3 = 32. The watermark is met when `fifo_count_i` is greater than or equal to it.
- R7: Once a frame has ended with a request due, `dma_req_o` stays high until `fifo_count_i` is seen at zero. It is low in the cycle after that edge.
- R8: A frame that ends bad after its request was already raised gives no discard strobe and holds the request as in R7.
- R9: The byte count restarts at every start of frame. The mode inputs are sampled only at start of frame, so changing them during a frame has no effect on that frame.
- R10: After reset, `dma_req_o` and `discard_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start-of-frame pulse (no byte in that cycle) |
| byte_vld_i | input | 1 | One received byte of the current frame entered the FIFO |
| eof_i | input | 1 | End-of-frame pulse (no byte in that cycle) |
| eof_good_i | input | 1 | Frame status qualifying `eof_i`: 1 = good |
| full_duplex_i | input | 1 | Full-duplex operation |
| runt_accept_i | input | 1 | Accept frames shorter than 64 bytes in half duplex |
| wm_sel_i | input | 2 | Watermark code (see R6) |
| fifo_count_i | input | 8 | Bytes currently held in the receive FIFO |
| dma_req_o | output | 1 | Request to the DMA engine to drain the FIFO |
| discard_o | output | 1 | One-cycle strobe: drop the frame that just ended |

## Verification
The hardest case to reach is a gated frame that crosses the 64-byte line and has its request raised, and then ends with an error. In that case the discard strobe must stay quiet and the request must stay up until the FIFO drains. The bench reaches it by driving the FIFO fill level itself, holding it above a high watermark during a frame longer than 64 bytes. It also places frames at exactly 63 and 64 bytes, with the level exactly at the 112-byte watermark, to test both sides of each boundary.

// File: rtl/rx_gate_pkg.sv
`timescale 1ns/1ps
package rx_gate_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RECV = 1'b1
  } gate_st_e;

  // Watermark in bytes for a 2-bit code, scaled by a unit size.
  function automatic int unsigned wm_bytes(input logic [1:0] sel, input int unsigned unit);
    case (sel)
      2'd0:    return unit;
      2'd1:    return unit * 4;
      2'd2:    return unit * 7;
      default: return unit * 2;
    endcase
  endfunction

endpackage

// File: rtl/rx_wm_decode.sv
`timescale 1ns/1ps
module rx_wm_decode #(
  parameter int CNT_W   = 8,
  parameter int WM_UNIT = 16
) (
  input  logic [1:0]       wm_sel_i,
  input  logic [CNT_W-1:0] fifo_count_i,
  output logic             wm_hit_o,
  output logic             fifo_empty_o
);
  import rx_gate_pkg::*;

  localparam int THR_W = CNT_W + 1;

  logic [THR_W-1:0] thr;

  always_comb begin
    thr          = THR_W'(wm_bytes(wm_sel_i, WM_UNIT));
    wm_hit_o     = {1'b0, fifo_count_i} >= thr;
    fifo_empty_o = (fifo_count_i == '0);
  end

  always_comb begin
    if (wm_hit_o) AST_WM_NONZERO: assert (fifo_count_i != '0); // R6
  end

endmodule

// File: rtl/rx_byte_tracker.sv
`timescale 1ns/1ps
module rx_byte_tracker #(
  parameter int MIN_FRAME = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sof_i,
  input  logic byte_vld_i,
  input  logic active_i,
  output logic safe_o
);
  localparam int PW = $clog2(MIN_FRAME + 1);
  localparam logic [PW-1:0] LIMIT = PW'(MIN_FRAME);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sof_i) begin
      cnt_q <= '0;
    end else if (byte_vld_i && active_i && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign safe_o = (cnt_q == LIMIT);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT); // R1

  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> !safe_o); // R9

endmodule

// File: rtl/rx_gate_fsm.sv
`timescale 1ns/1ps
module rx_gate_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic sof_i,
  input  logic eof_i,
  input  logic eof_good_i,
  input  logic full_duplex_i,
  input  logic runt_accept_i,
  input  logic safe_i,
  input  logic wm_hit_i,
  input  logic fifo_empty_i,
  output logic active_o,
  output logic frame_req_o,
  output logic drain_pend_o,
  output logic discard_o
);
  import rx_gate_pkg::*;

  gate_st_e st_q;
  logic     bypass_q;
  logic     frame_req_q;
  logic     drain_q;
  logic     discard_q;
  logic     qualify;
  logic     in_frame;

  assign in_frame = (st_q == ST_RECV);
  assign qualify  = bypass_q | safe_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      bypass_q    <= 1'b0;
      frame_req_q <= 1'b0;
      drain_q     <= 1'b0;
      discard_q   <= 1'b0;
    end else begin
      discard_q <= 1'b0;
      if (drain_q && fifo_empty_i) drain_q <= 1'b0;
      if (in_frame) begin
        if (eof_i || sof_i) begin
          // Frame closes (or is abandoned by a new start).
          if (frame_req_q || (eof_i && eof_good_i && qualify)) drain_q <= 1'b1;
          else                                                 discard_q <= 1'b1;
          frame_req_q <= 1'b0;
          st_q        <= ST_IDLE;
        end else if (qualify && wm_hit_i) begin
          frame_req_q <= 1'b1;
        end
      end
      if (sof_i) begin
        st_q     <= ST_RECV;
        bypass_q <= full_duplex_i | runt_accept_i;
      end
    end
  end

  assign active_o     = in_frame;
  assign frame_req_o  = frame_req_q;
  assign drain_pend_o = drain_q;
  assign discard_o    = discard_q;

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_req_q) && !bypass_q) |-> $past(safe_i)); // R1

  AST_DISCARD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    discard_q |-> !$past(frame_req_q)); // R3

  AST_DISCARD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    discard_q |=> !discard_q); // R3

  AST_DRAIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_q && fifo_empty_i && !(in_frame && (eof_i || sof_i))) |=> !drain_q); // R7

endmodule

// File: rtl/rx_dma_gate.sv
`timescale 1ns/1ps
module rx_dma_gate #(
  parameter int CNT_W     = 8,
  parameter int WM_UNIT   = 16,
  parameter int MIN_FRAME = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_i,
  input  logic             byte_vld_i,
  input  logic             eof_i,
  input  logic             eof_good_i,
  input  logic             full_duplex_i,
  input  logic             runt_accept_i,
  input  logic [1:0]       wm_sel_i,
  input  logic [CNT_W-1:0] fifo_count_i,
  output logic             dma_req_o,
  output logic             discard_o
);

  logic wm_hit;
  logic fifo_empty;
  logic safe;
  logic active;
  logic frame_req;
  logic drain_pend;

  rx_wm_decode #(.CNT_W(CNT_W), .WM_UNIT(WM_UNIT)) u_wm (
    .wm_sel_i     (wm_sel_i),
    .fifo_count_i (fifo_count_i),
    .wm_hit_o     (wm_hit),
    .fifo_empty_o (fifo_empty)
  );

  rx_byte_tracker #(.MIN_FRAME(MIN_FRAME)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof_i      (sof_i),
    .byte_vld_i (byte_vld_i),
    .active_i   (active),
    .safe_o     (safe)
  );

  rx_gate_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .sof_i         (sof_i),
    .eof_i         (eof_i),
    .eof_good_i    (eof_good_i),
    .full_duplex_i (full_duplex_i),
    .runt_accept_i (runt_accept_i),
    .safe_i        (safe),
    .wm_hit_i      (wm_hit),
    .fifo_empty_i  (fifo_empty),
    .active_o      (active),
    .frame_req_o   (frame_req),
    .drain_pend_o  (drain_pend),
    .discard_o     (discard_o)
  );

  assign dma_req_o = frame_req | drain_pend;

  AST_NO_REQ_AND_DISCARD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    discard_o |-> !frame_req); // R3

endmodule

// File: tb/test_rx_dma_gate.sv
`timescale 1ns/1ps
module test_rx_dma_gate;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0, bv = 1'b0, eof = 1'b0, good = 1'b0;
  logic       fd = 1'b0, ra = 1'b0;
  logic [1:0] wm = 2'd0;
  logic [7:0] lvl = 8'd0;
  logic       req, disc;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  rx_dma_gate i_rx_dma_gate (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(bv), .eof_i(eof),
    .eof_good_i(good), .full_duplex_i(fd), .runt_accept_i(ra), .wm_sel_i(wm),
    .fifo_count_i(lvl), .dma_req_o(req), .discard_o(disc)
  );

  // {fd, ra, wm, nbytes, fifo level, good}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 8'd80,  8'd20,  1'b1},  // R2 gated, wm 16 met after 64
    {1'b0, 1'b0, 2'd0, 8'd40,  8'd20,  1'b1},  // R1 R3 short good -> drop
    {1'b0, 1'b0, 2'd1, 8'd100, 8'd30,  1'b1},  // R2 wm 64 unmet, good end
    {1'b0, 1'b0, 2'd2, 8'd70,  8'd120, 1'b0},  // R8 bad after request
    {1'b0, 1'b0, 2'd3, 8'd70,  8'd10,  1'b0},  // R3 bad, no request yet
    {1'b1, 1'b0, 2'd0, 8'd10,  8'd20,  1'b1},  // R4 wm met on short frame
    {1'b1, 1'b0, 2'd1, 8'd20,  8'd30,  1'b1},  // R4 short complete frame
    {1'b1, 1'b0, 2'd1, 8'd20,  8'd30,  1'b0},  // R4 bad -> drop
    {1'b0, 1'b1, 2'd3, 8'd30,  8'd40,  1'b1},  // R5 wm 32 met, runt
    {1'b0, 1'b1, 2'd2, 8'd50,  8'd111, 1'b0},  // R5 R6 one under 112, bad
    {1'b0, 1'b0, 2'd2, 8'd64,  8'd112, 1'b1},  // R1 R6 exact boundaries
    {1'b0, 1'b0, 2'd3, 8'd63,  8'd40,  1'b1}   // R3 one byte short
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic int unsigned wm_val(input logic [1:0] s);
    case (s) 2'd0: return 16; 2'd1: return 64; 2'd2: return 112; default: return 32; endcase
  endfunction

  task automatic run_frame(input logic f_fd, input logic f_ra, input logic [1:0] f_wm,
                           input int nb, input logic [7:0] f_lvl, input logic f_good,
                           input string tag);
    logic byp, mid, held;
    byp  = f_fd | f_ra;
    mid  = (byp || nb >= 64) && (int'(f_lvl) >= wm_val(f_wm));
    held = mid || (f_good && (byp || nb >= 64));
    fd = f_fd; ra = f_ra; wm = f_wm; lvl = f_lvl;
    sof = 1'b1; tick(); sof = 1'b0;
    for (int i = 0; i < nb; i++) begin
      bv = 1'b1; tick();
    end
    bv = 1'b0; tick(); tick();
    chk({tag, " request before end"}, req, mid);
    eof = 1'b1; good = f_good; tick(); eof = 1'b0; good = 1'b0;
    chk({tag, " discard strobe"}, disc, !held);
    chk({tag, " request after end"}, req, held);
    tick();
    chk({tag, " discard one cycle"}, disc, 1'b0);
    chk({tag, " R7 held while fifo nonempty"}, req, held);
    lvl = 8'd0; tick();
    chk({tag, " R7 drops on empty"}, req, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick();
    chk("R10 reset request", req, 1'b0);
    chk("R10 reset discard", disc, 1'b0);
    rst_n = 1'b1; tick();
    chk("R10 idle request", req, 1'b0);

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][20], VEC[v][19], VEC[v][18:17], int'(VEC[v][16:9]),
                VEC[v][8:1], VEC[v][0], $sformatf("vec%0d R1 R2 R3 R4 R5 R6", v));
    end

    // R9: mode raised mid-frame is ignored for that frame.
    fd = 1'b0; ra = 1'b0; wm = 2'd0; lvl = 8'd100;
    sof = 1'b1; tick(); sof = 1'b0;
    fd = 1'b1;
    for (int i = 0; i < 30; i++) begin bv = 1'b1; tick(); end
    bv = 1'b0; tick(); tick();
    chk("R9 late full duplex ignored", req, 1'b0);
    eof = 1'b1; good = 1'b1; tick(); eof = 1'b0; good = 1'b0;
    chk("R9 short frame still dropped", disc, 1'b1);
    lvl = 8'd0; tick();

    // R9: byte count restarts at start of frame (two 40-byte frames, gated).
    fd = 1'b0; lvl = 8'd20;
    sof = 1'b1; tick(); sof = 1'b0;
    for (int i = 0; i < 40; i++) begin bv = 1'b1; tick(); end
    bv = 1'b0; eof = 1'b1; good = 1'b1; tick(); eof = 1'b0; good = 1'b0;
    chk("R9 first short frame drop", disc, 1'b1);
    sof = 1'b1; tick(); sof = 1'b0;
    for (int i = 0; i < 40; i++) begin bv = 1'b1; tick(); end
    bv = 1'b0; tick(); tick();
    chk("R9 count restarted no request", req, 1'b0);
    eof = 1'b1; good = 1'b1; tick(); eof = 1'b0; good = 1'b0;
    chk("R9 second short frame drop", disc, 1'b1);
    lvl = 8'd0; tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule